// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps three 256-entry vector bitmaps for one processor's local interrupt controller. The request bitmap holds interrupts that have arrived and not yet been taken. The in-service bitmap holds interrupts the processor has taken and not yet retired. The trigger bitmap records whether each vector was raised as a level or an edge. Fixed-mode requests come in on an accept port as a vector and a trigger kind. The processor takes the offered vector through an acknowledge strobe and retires it with an end-of-interrupt strobe.

A task priority value set by software is combined with the class of the highest in-service vector to form the processor priority. A vector's class is its upper four bits. The highest pending request is offered only when its class is strictly above that priority. Each end-of-interrupt produces a one-cycle report carrying the retired vector and its trigger kind, so that an upstream router can re-arm level sources.

Top module: `irq_prio_ctrl`

## Requirements
- R1: An accept while enabled sets the vector's request bit, and `acc_taken_o` is high in the same cycle. If that request bit is already set, `acc_taken_o` is low and the request merges into the pending one.
- R2: An enabled accept sets the vector's trigger bit when `acc_level_i`=1 and clears it when `acc_level_i`=0, whether or not the request merges. A later retire of that vector reports this value on `eoi_level_o` (1 = level, 0 = edge).
- R3: When `hw_en_i` or `sw_en_i` is low, an accept is dropped, leaving request and trigger bits unchanged, and `intr_valid_o` is low.
- R4: `ppr_o` equals the task priority when the task priority's upper nibble is at least the upper nibble of the highest in-service vector. Otherwise it equals that vector with its low nibble cleared. An empty in-service set counts as vector 0.
- R5: `intr_valid_o` is high only when enabled and a request exists whose highest vector, with its low nibble cleared, is strictly greater than `ppr_o`. `intr_vector_o` is the highest pending vector.
- R6: `ack_i` while `intr_valid_o` is high clears the offered vector's request bit and sets its in-service bit at the next edge. `ack_i` with `intr_valid_o` low has no effect.
- R7: `eoi_we_i` clears the highest in-service bit and clears that vector's trigger bit. In the next cycle `eoi_valid_o` pulses for one cycle with `eoi_vector_o` and `eoi_level_o` holding the trigger bit as it stood before the clear.
- R8: `eoi_we_i` with an empty in-service set changes no state and produces no `eoi_valid_o` pulse.
- R9: Accept, acknowledge and end-of-interrupt in one cycle apply in that order at a single edge. An end-of-interrupt together with an acknowledge therefore retires the vector just acknowledged.
- R10: Reset clears all three bitmaps, the task priority and the end-of-interrupt report.
- R11: `tpr_we_i` loads `tpr_wdata_i` at the next edge. `tpr_o` shows it, and the priority comparison uses it, from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_en_i | input | 1 | Hardware enable |
| sw_en_i | input | 1 | Software enable |
| acc_valid_i | input | 1 | Fixed-mode request strobe |
| acc_vector_i | input | 8 | Requested vector |
| acc_level_i | input | 1 | Request trigger kind, 1 = level |
| acc_taken_o | output | 1 | Request newly recorded (low if dropped or merged) |
| tpr_we_i | input | 1 | Task priority write strobe |
| tpr_wdata_i | input | 8 | Task priority write data |
| eoi_we_i | input | 1 | End-of-interrupt write strobe |
| ack_i | input | 1 | Processor acknowledge of offered vector |
| intr_valid_o | output | 1 | A vector is offered |
| intr_vector_o | output | 8 | Offered vector |
| tpr_o | output | 8 | Current task priority |
| ppr_o | output | 8 | Current processor priority |
| eoi_valid_o | output | 1 | One-cycle retire report |
| eoi_vector_o | output | 8 | Retired vector |
| eoi_level_o | output | 1 | Retired vector was level triggered |

## Verification
Every cycle, the embedded properties check a few things. The processor priority never falls below the task priority. An offered vector always has its request bit set. An acknowledge moves a vector from request to in-service. Dropped accepts leave no request behind, retire reports follow a retire strobe, and a retire on an empty in-service set stays silent. Other behaviour depends on history and only the bench scenarios show it. This covers the merge of a repeated request, the trigger kind carried through to the retire report, and the strict class comparison that holds back a request in the same class as the running one. It also covers the same-cycle order of accept, acknowledge and retire, which a behavioural model checks on every clock.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned DEF_VEC_W   = 8;
  localparam int unsigned DEF_WORD_W  = 32;
  localparam int unsigned DEF_CLASS_W = 4;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/vec_prio_enc.sv
module vec_prio_enc #(
  parameter int unsigned VEC_W  = irq_prio_pkg::DEF_VEC_W,
  parameter int unsigned WORD_W = irq_prio_pkg::DEF_WORD_W
) (
  input  logic [(1<<VEC_W)-1:0] bits_i,
  output logic                  any_o,
  output logic [VEC_W-1:0]      top_o
);
  localparam int unsigned NUM_VEC   = 1 << VEC_W;
  localparam int unsigned NUM_WORDS = NUM_VEC / WORD_W;
  localparam int unsigned BIT_W     = $clog2(WORD_W);
  localparam int unsigned WIDX_W    = VEC_W - BIT_W;

  logic [NUM_WORDS-1:0] word_any;
  logic [BIT_W-1:0]     word_msb [NUM_WORDS];

  // first level: msb inside each word
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word;
    assign word        = bits_i[w*WORD_W +: WORD_W];
    assign word_any[w] = |word;
    always_comb begin
      word_msb[w] = '0;
      for (int b = 0; b < WORD_W; b++)
        if (word[b]) word_msb[w] = BIT_W'(b);
    end
  end

  // second level: highest non-empty word
  logic [WIDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (word_any[w]) sel = WIDX_W'(w);
  end

  assign any_o = |word_any;
  assign top_o = any_o ? {sel, word_msb[sel]} : '0;
endmodule

// File: rtl/prio_ppr.sv
module prio_ppr #(
  parameter int unsigned VEC_W   = irq_prio_pkg::DEF_VEC_W,
  parameter int unsigned CLASS_W = irq_prio_pkg::DEF_CLASS_W
) (
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             isr_any_i,
  input  logic [VEC_W-1:0] isr_top_i,
  output logic [VEC_W-1:0] ppr_o
);
  localparam int unsigned LOW_W = VEC_W - CLASS_W;

  logic [CLASS_W-1:0] tpr_cls, isr_cls;

  assign tpr_cls = tpr_i[VEC_W-1 -: CLASS_W];
  assign isr_cls = isr_any_i ? isr_top_i[VEC_W-1 -: CLASS_W] : '0;
  assign ppr_o   = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {LOW_W{1'b0}}};
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned VEC_W   = irq_prio_pkg::DEF_VEC_W,
  parameter int unsigned WORD_W  = irq_prio_pkg::DEF_WORD_W,
  parameter int unsigned CLASS_W = irq_prio_pkg::DEF_CLASS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_en_i,
  input  logic             sw_en_i,
  input  logic             acc_valid_i,
  input  logic [VEC_W-1:0] acc_vector_i,
  input  logic             acc_level_i,
  output logic             acc_taken_o,
  input  logic             tpr_we_i,
  input  logic [VEC_W-1:0] tpr_wdata_i,
  input  logic             eoi_we_i,
  input  logic             ack_i,
  output logic             intr_valid_o,
  output logic [VEC_W-1:0] intr_vector_o,
  output logic [VEC_W-1:0] tpr_o,
  output logic [VEC_W-1:0] ppr_o,
  output logic             eoi_valid_o,
  output logic [VEC_W-1:0] eoi_vector_o,
  output logic             eoi_level_o
);
  import irq_prio_pkg::*;

  localparam int unsigned NUM_VEC = 1 << VEC_W;
  localparam int unsigned LOW_W   = VEC_W - CLASS_W;

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
  logic [NUM_VEC-1:0] acc_mask, ack_mask, eoi_mask, tmr_mid;
  logic [VEC_W-1:0]   tpr_q;
  logic               eoi_valid_q;
  logic [VEC_W-1:0]   eoi_vec_q;
  trig_e              eoi_kind_q;

  logic               irr_any, isr_any;
  logic [VEC_W-1:0]   irr_top, isr_top, ppr;
  logic               enabled, acc_hit, offer_ok, ack_fire, eoi_fire;
  logic [VEC_W-1:0]   eoi_vec;
  trig_e              eoi_kind;

  vec_prio_enc #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_irr_enc (
    .bits_i(irr_q), .any_o(irr_any), .top_o(irr_top)
  );

  vec_prio_enc #(.VEC_W(VEC_W), .WORD_W(WORD_W)) u_isr_enc (
    .bits_i(isr_q), .any_o(isr_any), .top_o(isr_top)
  );

  prio_ppr #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_ppr (
    .tpr_i(tpr_q), .isr_any_i(isr_any), .isr_top_i(isr_top), .ppr_o(ppr)
  );

  assign enabled  = hw_en_i & sw_en_i;
  assign acc_hit  = acc_valid_i & enabled;
  assign offer_ok = enabled & irr_any &
                    ({irr_top[VEC_W-1 -: CLASS_W], {LOW_W{1'b0}}} > ppr);
  assign ack_fire = ack_i & offer_ok;

  assign acc_mask = acc_hit  ? (NUM_VEC'(1) << acc_vector_i) : '0;
  assign ack_mask = ack_fire ? (NUM_VEC'(1) << irr_top)      : '0;

  // order: accept, then acknowledge, then retire
  assign tmr_mid  = acc_level_i ? (tmr_q | acc_mask) : (tmr_q & ~acc_mask);

  // an acked vector's class exceeds every in-service class, so it is the top
  assign eoi_fire = eoi_we_i & (isr_any | ack_fire);
  assign eoi_vec  = ack_fire ? irr_top : isr_top;
  assign eoi_mask = eoi_fire ? (NUM_VEC'(1) << eoi_vec) : '0;
  assign eoi_kind = trig_e'(tmr_mid[eoi_vec]);

  assign irr_d = (irr_q | acc_mask) & ~ack_mask;
  assign isr_d = (isr_q | ack_mask) & ~eoi_mask;
  assign tmr_d = tmr_mid & ~eoi_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q       <= '0;
      isr_q       <= '0;
      tmr_q       <= '0;
      tpr_q       <= '0;
      eoi_valid_q <= 1'b0;
      eoi_vec_q   <= '0;
      eoi_kind_q  <= TRIG_EDGE;
    end else begin
      irr_q       <= irr_d;
      isr_q       <= isr_d;
      tmr_q       <= tmr_d;
      eoi_valid_q <= eoi_fire;
      if (tpr_we_i) tpr_q <= tpr_wdata_i;
      if (eoi_fire) begin
        eoi_vec_q  <= eoi_vec;
        eoi_kind_q <= eoi_kind;
      end
    end
  end

  assign acc_taken_o   = acc_hit & ~irr_q[acc_vector_i];
  assign intr_valid_o  = offer_ok;
  assign intr_vector_o = irr_top;
  assign tpr_o         = tpr_q;
  assign ppr_o         = ppr;
  assign eoi_valid_o   = eoi_valid_q;
  assign eoi_vector_o  = eoi_vec_q;
  assign eoi_level_o   = (eoi_kind_q == TRIG_LEVEL);

  p_ppr_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o >= tpr_o);

  p_offer_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_valid_o |-> irr_q[intr_vector_o]);

  p_ack_moves_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && intr_valid_o && !eoi_we_i) |=>
      (!irr_q[$past(intr_vector_o)] && isr_q[$past(intr_vector_o)]));

  p_drop_disabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !(hw_en_i && sw_en_i) && !irr_q[acc_vector_i]) |=>
      !irr_q[$past(acc_vector_i)]);

  p_eoi_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_valid_o |-> $past(eoi_we_i));

  p_eoi_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_we_i && isr_q == '0 && !(ack_i && intr_valid_o)) |=> !eoi_valid_o);

  p_tpr_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpr_we_i |=> tpr_o == $past(tpr_wdata_i));
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hw_en_i = 1'b0, sw_en_i = 1'b0;
  logic       acc_valid_i = 1'b0, acc_level_i = 1'b0;
  logic [7:0] acc_vector_i = '0;
  logic       tpr_we_i = 1'b0, eoi_we_i = 1'b0, ack_i = 1'b0;
  logic [7:0] tpr_wdata_i = '0;
  logic       acc_taken_o, intr_valid_o, eoi_valid_o, eoi_level_o;
  logic [7:0] intr_vector_o, tpr_o, ppr_o, eoi_vector_o;

  irq_prio_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0;

  // behavioural reference state
  logic [255:0] m_irr, m_isr, m_tmr;
  int m_tpr, m_eoi_vec;
  bit m_eoi_v, m_eoi_lvl;

  function automatic int highest(logic [255:0] b);
    int r = -1;
    for (int i = 0; i < 256; i++) if (b[i]) r = i;
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_irr = '0; m_isr = '0; m_tmr = '0;
    m_tpr = 0; m_eoi_v = 0; m_eoi_vec = 0; m_eoi_lvl = 0;
  endtask

  function automatic int m_ppr();
    int it = highest(m_isr);
    int iv = (it < 0) ? 0 : it;
    return ((m_tpr >> 4) >= (iv >> 4)) ? m_tpr : (iv & 'hF0);
  endfunction

  // compare every output, then advance model at the edge
  task automatic tick();
    bit en;
    int top, ppr, e;
    bit valid;
    #1;
    en    = hw_en_i && sw_en_i;
    top   = highest(m_irr);
    ppr   = m_ppr();
    valid = en && top >= 0 && ((top & 'hF0) > ppr);
    chk("R1 acc_taken", acc_taken_o, int'(en && acc_valid_i && !m_irr[acc_vector_i]));
    chk("R4 ppr", ppr_o, ppr);
    chk("R5 intr_valid", intr_valid_o, int'(valid));
    if (valid) chk("R5 intr_vector", intr_vector_o, top);
    chk("R11 tpr", tpr_o, m_tpr);
    chk("R7 eoi_valid", eoi_valid_o, int'(m_eoi_v));
    if (m_eoi_v) begin
      chk("R7 eoi_vector", eoi_vector_o, m_eoi_vec);
      chk("R2 eoi_level", eoi_level_o, int'(m_eoi_lvl));
    end
    @(posedge clk_i);
    if (acc_valid_i && en) begin
      m_tmr[acc_vector_i] = acc_level_i;
      m_irr[acc_vector_i] = 1'b1;
    end
    if (ack_i && valid) begin
      m_isr[top] = 1'b1;
      m_irr[top] = 1'b0;
    end
    m_eoi_v = 0;
    if (eoi_we_i) begin
      e = highest(m_isr);
      if (e >= 0) begin
        m_isr[e]  = 1'b0;
        m_eoi_v   = 1;
        m_eoi_vec = e;
        m_eoi_lvl = m_tmr[e];
        m_tmr[e]  = 1'b0;
      end
    end
    if (tpr_we_i) m_tpr = tpr_wdata_i;
    @(negedge clk_i);
  endtask

  task automatic idle();
    acc_valid_i = 0; ack_i = 0; eoi_we_i = 0; tpr_we_i = 0;
  endtask

  task automatic accept(int v, bit lvl);
    idle(); acc_valid_i = 1; acc_vector_i = 8'(v); acc_level_i = lvl; tick(); idle();
  endtask

  task automatic set_tpr(int v);
    idle(); tpr_we_i = 1; tpr_wdata_i = 8'(v); tick(); idle();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    #1;
    chk("R10 ppr", ppr_o, 0);
    chk("R10 tpr", tpr_o, 0);
    chk("R10 intr_valid", intr_valid_o, 0);
    chk("R10 eoi_valid", eoi_valid_o, 0);
    hw_en_i = 1; sw_en_i = 1;
    @(negedge clk_i);

    // R1: fresh then merged request
    acc_valid_i = 1; acc_vector_i = 8'h45; acc_level_i = 0;
    #1 chk("R1 first take", acc_taken_o, 1);
    tick(); idle(); #1;
    chk("R5 offer", intr_valid_o, 1);
    chk("R5 offer vec", intr_vector_o, 'h45);
    acc_valid_i = 1; acc_vector_i = 8'h45;
    #1 chk("R1 merged", acc_taken_o, 0);
    tick(); idle();

    // R3: both enable legs
    sw_en_i = 0;
    acc_valid_i = 1; acc_vector_i = 8'h80; acc_level_i = 1;
    #1 chk("R3 sw off taken", acc_taken_o, 0);
    chk("R3 sw off offer", intr_valid_o, 0);
    tick(); idle(); sw_en_i = 1;
    hw_en_i = 0;
    acc_valid_i = 1; acc_vector_i = 8'h90;
    tick(); idle(); hw_en_i = 1; #1;
    chk("R3 dropped", intr_vector_o, 'h45);

    // R4/R5/R11: task priority gating
    set_tpr('h50); #1;
    chk("R11 tpr load", tpr_o, 'h50);
    chk("R5 masked", intr_valid_o, 0);
    chk("R4 ppr tpr", ppr_o, 'h50);
    set_tpr('h3F); #1;
    chk("R5 unmasked", intr_valid_o, 1);

    // R6: acknowledge
    ack_i = 1; tick(); idle(); #1;
    chk("R6 moved", intr_valid_o, 0);
    chk("R4 ppr isr", ppr_o, 'h40);
    ack_i = 1; tick(); idle();   // ack with nothing offered

    // R5 strict class compare
    accept('h47, 1);
    accept('h30, 0); #1;
    chk("R5 same class", intr_valid_o, 0);

    // R7: retire edge vector
    eoi_we_i = 1; tick(); idle(); #1;
    chk("R7 pulse", eoi_valid_o, 1);
    chk("R7 vec", eoi_vector_o, 'h45);
    chk("R7 edge", eoi_level_o, 0);
    chk("R4 ppr back", ppr_o, 'h3F);
    chk("R5 next", intr_vector_o, 'h47);

    // R2: level kind carried to retire
    ack_i = 1; tick(); idle();
    eoi_we_i = 1; tick(); idle(); #1;
    chk("R2 level", eoi_level_o, 1);
    chk("R2 vec", eoi_vector_o, 'h47);

    // R8: retire on empty
    eoi_we_i = 1; tick(); idle(); #1;
    chk("R8 silent", eoi_valid_o, 0);
    chk("R8 ppr", ppr_o, 'h3F);

    // R9: ack and retire together, plus merged accept
    set_tpr(0);
    ack_i = 1; eoi_we_i = 1; acc_valid_i = 1; acc_vector_i = 8'h30; acc_level_i = 1;
    tick(); idle(); #1;
    chk("R9 retire acked", eoi_vector_o, 'h30);
    chk("R9 level via accept", eoi_level_o, 1);
    chk("R9 ppr", ppr_o, 0);
    chk("R9 empty", intr_valid_o, 0);

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      acc_valid_i  = ($urandom % 3) == 0;
      acc_vector_i = ($urandom % 2) ? 8'($urandom) : 8'(16 * ($urandom % 16) + ($urandom % 3));
      acc_level_i  = $urandom % 2;
      ack_i        = ($urandom % 3) == 0;
      eoi_we_i     = ($urandom % 4) == 0;
      tpr_we_i     = ($urandom % 25) == 0;
      tpr_wdata_i  = 8'($urandom);
      hw_en_i      = ($urandom % 40) != 0;
      sw_en_i      = ($urandom % 40) != 0;
      tick();
    end
    idle(); hw_en_i = 1; sw_en_i = 1;
    tick();

    summary();
    $finish;
  end
endmodule